// File: doc/BRIEF.md
# Software-Refilled Set-Associative Translation Buffer

This block translates virtual addresses to physical addresses using a set-associative table of translation entries that is filled only by software. A lookup presents a virtual address, an access type, a privilege mode and the current address-space identifier. One clock later the block returns either a physical address with a cacheable flag, or a fault. The block never walks page tables itself.

On a miss or a permission violation the block raises an interrupt request. It also captures the faulting virtual address and a structured 16-bit cause code, and holds both for the handler to read. While the core reports that the handler is running, addresses pass through untranslated and no fault can arise. Software loads and reads whole 128-bit entries through a port that selects the set and the way. A single-cycle invalidate-all input empties the table.

A three-state trap controller sequences the request:

| State | Meaning |
|---|---|
| `ST_RUN` | Normal translation. |
| `ST_PEND` | A trap is latched and the interrupt request is high. |
| `ST_HANDLER` | The handler is active. |

| From | To | Condition |
|---|---|---|
| `ST_RUN` | `ST_HANDLER` | The handler flag rises. |
| `ST_RUN` | `ST_PEND` | A lookup faults. |
| `ST_PEND` | `ST_HANDLER` | The handler flag rises. |
| `ST_HANDLER` | `ST_RUN` | The handler flag falls with no fault. |
| `ST_HANDLER` | `ST_PEND` | The handler flag falls and the same cycle's lookup faults. |

In every other case the controller holds its state.

Top module: `sw_tlb`

## Requirements
- R1: A lookup hits when the entry at set `va[12 +: log2(SETS)]` in some way has its valid bit (bit 112) set, a 48-bit page tag (bits 47:0) equal to `va[59:12]`, and an 8-bit space tag (bits 111:104) equal to `req_asid`. On a permitted hit, `rsp_pa` one cycle later is the entry's frame number (bits 95:48) joined to `va[11:0]`, and `rsp_fault` is 0.
- R2: An entry whose space tag differs from `req_asid` does not hit. The lookup then reports a miss.
- R3: A lookup that hits no way, with `hnd_active` low, gives `rsp_fault`=1 (miss) and raises `irq` in the same cycle as the response. It also loads `trap_addr` with the full virtual address and `trap_cause` with `{16'h0, 4'h1, 4'h1, 5'b0, priv, acc}`.
- R4: The permission byte (bits 103:96) holds a user nibble in bits 3:0 and a supervisor nibble in bits 7:4, each ordered {cacheable, execute, write, read}. Access codes are 0 read, 1 write and 2 execute; code 3 is always denied. A hit whose access bit is clear for `req_priv` (1 = supervisor) gives `rsp_fault`=2 and raises `irq`, with the cause's kind field set to 2. Otherwise `rsp_cache` is the mode's cacheable bit.
- R5: `irq` stays high until `hnd_active` rises and falls in the next cycle. While `irq` is high, further faults do not change `trap_addr` or `trap_cause`.
- R6: While `hnd_active` is high, a lookup returns `rsp_pa` = `req_va`, `rsp_fault`=0 and `rsp_cache`=0. It raises no interrupt and leaves the trap registers unchanged.
- R7: A software entry write takes effect for lookups issued in the next cycle. A lookup issued in the same cycle as the write sees the previous contents.
- R8: `sw_rdata` returns, one cycle after `sw_set`/`sw_way` are presented, the 128-bit entry stored there, including its current valid bit.
- R9: A one-cycle `inv_all` clears every valid bit. Lookups issued afterwards miss, and read-back shows bit 112 clear. A write in the same cycle as `inv_all` stores its data with the valid bit cleared.
- R10: After the handler flag falls, the block translates again and a new fault traps afresh, with new trap values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_va | input | 60 | Virtual address |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| req_priv | input | 1 | 1 = supervisor mode |
| req_asid | input | 8 | Current address-space identifier |
| hnd_active | input | 1 | Trap handler running; bypasses translation |
| inv_all | input | 1 | Clear all valid bits |
| sw_we | input | 1 | Entry write strobe |
| sw_set | input | log2(SETS) | Selected set |
| sw_way | input | log2(WAYS) | Selected way |
| sw_wdata | input | 128 | Entry to write |
| sw_rdata | output | 128 | Entry read back |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_pa | output | 60 | Physical address |
| rsp_cache | output | 1 | Cacheable flag |
| rsp_fault | output | 2 | 0 none, 1 miss, 2 protection |
| irq | output | 1 | Trap interrupt request |
| trap_addr | output | 60 | Latched faulting address |
| trap_cause | output | 32 | Cause; low 16 bits hold the code |

## Verification
The assertions assume that `hnd_active` rises only in response to `irq` or to some other trap, and that it is never high for a lookup that software expects to be translated. The bench raises it only for the handler step and for the bypass test. The assertions also assume that software never loads two valid entries with the same tag and space identifier into one set. The bench therefore writes at most one entry per page, and it follows every trapping lookup with a handler rise-and-fall before starting the next scenario.

// File: rtl/sw_tlb_pkg.sv
package sw_tlb_pkg;
    localparam int VPN_W  = 48;
    localparam int PPN_W  = 48;
    localparam int OFF_W  = 12;
    localparam int ASID_W = 8;
    localparam int PERM_W = 8;
    localparam int ENT_W  = 128;
    localparam int RSV_W  = ENT_W - VPN_W - PPN_W - PERM_W - ASID_W - 1;
    localparam int VA_W   = VPN_W + OFF_W;
    localparam int PA_W   = PPN_W + OFF_W;

    typedef struct packed {
        logic [RSV_W-1:0]  rsv;
        logic              valid;
        logic [ASID_W-1:0] asid;
        logic [PERM_W-1:0] perm;
        logic [PPN_W-1:0]  ppn;
        logic [VPN_W-1:0]  vpn;
    } ent_t;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_MISS = 2'd1,
        FLT_PROT = 2'd2
    } flt_e;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_PEND    = 2'd1,
        ST_HANDLER = 2'd2
    } tst_e;

    localparam logic [3:0] CAUSE_UNIT = 4'h1;
endpackage

// File: rtl/sw_tlb_store.sv
module sw_tlb_store
    import sw_tlb_pkg::*;
#(
    parameter int SETS  = 64,
    parameter int WAYS  = 4,
    parameter int SET_W = $clog2(SETS),
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv_all,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [WAY_W-1:0]  wr_way,
    input  ent_t              wr_data,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [WAY_W-1:0]  rd_way,
    output ent_t              rd_data,
    input  logic [SET_W-1:0]  lk_set,
    output logic              lk_vld  [WAYS],
    output logic [VPN_W-1:0]  lk_vpn  [WAYS],
    output logic [PPN_W-1:0]  lk_ppn  [WAYS],
    output logic [PERM_W-1:0] lk_perm [WAYS],
    output logic [ASID_W-1:0] lk_asid [WAYS]
);
    ent_t mem_q [SETS][WAYS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    mem_q[s][w].valid <= 1'b0;
                end
            end
        end else begin
            if (wr_en) begin
                mem_q[wr_set][wr_way] <= wr_data;
            end
            if (inv_all) begin
                for (int s = 0; s < SETS; s++) begin
                    for (int w = 0; w < WAYS; w++) begin
                        mem_q[s][w].valid <= 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= mem_q[rd_set][rd_way];
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way_rd
        assign lk_vld[w]  = mem_q[lk_set][w].valid;
        assign lk_vpn[w]  = mem_q[lk_set][w].vpn;
        assign lk_ppn[w]  = mem_q[lk_set][w].ppn;
        assign lk_perm[w] = mem_q[lk_set][w].perm;
        assign lk_asid[w] = mem_q[lk_set][w].asid;
    end
endmodule

// File: rtl/sw_tlb_match.sv
module sw_tlb_match
    import sw_tlb_pkg::*;
#(
    parameter int WAYS = 4
) (
    input  logic              lk_vld  [WAYS],
    input  logic [VPN_W-1:0]  lk_vpn  [WAYS],
    input  logic [PPN_W-1:0]  lk_ppn  [WAYS],
    input  logic [PERM_W-1:0] lk_perm [WAYS],
    input  logic [ASID_W-1:0] lk_asid [WAYS],
    input  logic [VPN_W-1:0]  vpn,
    input  logic [ASID_W-1:0] asid,
    output logic              hit,
    output logic [PPN_W-1:0]  sel_ppn,
    output logic [PERM_W-1:0] sel_perm
);
    logic [WAYS-1:0] hit_vec;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = lk_vld[w] && (lk_vpn[w] == vpn) && (lk_asid[w] == asid);
    end

    assign hit = |hit_vec;

    always_comb begin
        sel_ppn  = '0;
        sel_perm = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                sel_ppn  = lk_ppn[w];
                sel_perm = lk_perm[w];
            end
        end
    end
endmodule

// File: rtl/sw_tlb_trap.sv
module sw_tlb_trap
    import sw_tlb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fault_ev,
    input  logic            hnd_active,
    input  logic [VA_W-1:0] ev_va,
    input  logic [15:0]     ev_code,
    output logic            irq,
    output logic [VA_W-1:0] trap_addr,
    output logic [31:0]     trap_cause
);
    tst_e state_q, state_d;
    logic take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (hnd_active)     state_d = ST_HANDLER;
                else if (fault_ev)  state_d = ST_PEND;
            end
            ST_PEND: begin
                if (hnd_active)     state_d = ST_HANDLER;
            end
            ST_HANDLER: begin
                if (!hnd_active)    state_d = fault_ev ? ST_PEND : ST_RUN;
            end
            default:                state_d = ST_RUN;
        endcase
    end

    always_comb begin
        irq  = (state_q == ST_PEND);
        take = fault_ev && (state_q != ST_PEND) && !hnd_active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trap_addr  <= '0;
            trap_cause <= '0;
        end else if (take) begin
            trap_addr  <= ev_va;
            trap_cause <= {16'h0000, ev_code};
        end
    end
endmodule

// File: rtl/sw_tlb.sv
module sw_tlb
    import sw_tlb_pkg::*;
#(
    parameter int SETS = 64,
    parameter int WAYS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [VA_W-1:0]          req_va,
    input  logic [1:0]               req_acc,
    input  logic                     req_priv,
    input  logic [ASID_W-1:0]        req_asid,
    input  logic                     hnd_active,
    input  logic                     inv_all,
    input  logic                     sw_we,
    input  logic [$clog2(SETS)-1:0]  sw_set,
    input  logic [$clog2(WAYS)-1:0]  sw_way,
    input  logic [ENT_W-1:0]         sw_wdata,
    output logic [ENT_W-1:0]         sw_rdata,
    output logic                     rsp_valid,
    output logic [PA_W-1:0]          rsp_pa,
    output logic                     rsp_cache,
    output logic [1:0]               rsp_fault,
    output logic                     irq,
    output logic [VA_W-1:0]          trap_addr,
    output logic [31:0]              trap_cause
);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);

    logic              lk_vld  [WAYS];
    logic [VPN_W-1:0]  lk_vpn  [WAYS];
    logic [PPN_W-1:0]  lk_ppn  [WAYS];
    logic [PERM_W-1:0] lk_perm [WAYS];
    logic [ASID_W-1:0] lk_asid [WAYS];
    logic              hit;
    logic [PPN_W-1:0]  sel_ppn;
    logic [PERM_W-1:0] sel_perm;
    ent_t              rd_ent;
    ent_t              wr_ent;

    logic [VPN_W-1:0]  va_vpn;
    logic [SET_W-1:0]  va_set;
    logic [3:0]        mode_perm;
    logic              perm_ok;
    flt_e              flt_d;
    logic [PA_W-1:0]   pa_d;
    logic              cache_d;
    logic              fault_ev;
    logic [15:0]       code_d;

    assign va_vpn   = req_va[OFF_W +: VPN_W];
    assign va_set   = req_va[OFF_W +: SET_W];
    assign wr_ent   = ent_t'(sw_wdata);
    assign sw_rdata = ENT_W'(rd_ent);

    sw_tlb_store #(.SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .inv_all (inv_all),
        .wr_en   (sw_we),
        .wr_set  (sw_set),
        .wr_way  (sw_way),
        .wr_data (wr_ent),
        .rd_set  (sw_set),
        .rd_way  (sw_way),
        .rd_data (rd_ent),
        .lk_set  (va_set),
        .lk_vld  (lk_vld),
        .lk_vpn  (lk_vpn),
        .lk_ppn  (lk_ppn),
        .lk_perm (lk_perm),
        .lk_asid (lk_asid)
    );

    sw_tlb_match #(.WAYS(WAYS)) u_match (
        .lk_vld   (lk_vld),
        .lk_vpn   (lk_vpn),
        .lk_ppn   (lk_ppn),
        .lk_perm  (lk_perm),
        .lk_asid  (lk_asid),
        .vpn      (va_vpn),
        .asid     (req_asid),
        .hit      (hit),
        .sel_ppn  (sel_ppn),
        .sel_perm (sel_perm)
    );

    always_comb begin
        mode_perm = req_priv ? sel_perm[7:4] : sel_perm[3:0];
        unique case (req_acc)
            2'd0:    perm_ok = mode_perm[0];
            2'd1:    perm_ok = mode_perm[1];
            2'd2:    perm_ok = mode_perm[2];
            default: perm_ok = 1'b0;
        endcase

        if (hnd_active) begin
            flt_d   = FLT_NONE;
            pa_d    = PA_W'(req_va);
            cache_d = 1'b0;
        end else if (!hit) begin
            flt_d   = FLT_MISS;
            pa_d    = '0;
            cache_d = 1'b0;
        end else if (!perm_ok) begin
            flt_d   = FLT_PROT;
            pa_d    = '0;
            cache_d = 1'b0;
        end else begin
            flt_d   = FLT_NONE;
            pa_d    = {sel_ppn, req_va[OFF_W-1:0]};
            cache_d = mode_perm[3];
        end

        fault_ev = req_valid && (flt_d != FLT_NONE);
        code_d   = {CAUSE_UNIT, {2'b00, flt_d}, 5'b00000, req_priv, req_acc};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_pa    <= '0;
            rsp_cache <= 1'b0;
            rsp_fault <= FLT_NONE;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_pa    <= pa_d;
                rsp_cache <= cache_d;
                rsp_fault <= flt_d;
            end else begin
                rsp_cache <= 1'b0;
                rsp_fault <= FLT_NONE;
            end
        end
    end

    sw_tlb_trap u_trap (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault_ev   (fault_ev),
        .hnd_active (hnd_active),
        .ev_va      (req_va),
        .ev_code    (code_d),
        .irq        (irq),
        .trap_addr  (trap_addr),
        .trap_cause (trap_cause)
    );
endmodule

// File: rtl/sw_tlb_chk.sv
module sw_tlb_chk #(
    parameter int VA_W = 60
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [VA_W-1:0] req_va,
    input logic            hnd_active,
    input logic            inv_all,
    input logic            rsp_valid,
    input logic [VA_W-1:0] rsp_pa,
    input logic [1:0]      rsp_fault,
    input logic            irq,
    input logic [VA_W-1:0] trap_addr,
    input logic [31:0]     trap_cause
);
    AST_FAULT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd0) |-> irq); // R3

    AST_CAUSE_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (trap_cause[15:12] == 4'h1 && trap_cause[31:16] == 16'h0)); // R3

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !hnd_active) |=> irq); // R5

    AST_TRAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(irq)) |-> ($stable(trap_addr) && $stable(trap_cause))); // R5

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hnd_active) |=> (rsp_valid && rsp_fault == 2'd0 && rsp_pa == $past(req_va))); // R6

    AST_INV_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_all ##1 (req_valid && !hnd_active)) |=> (rsp_fault == 2'd1)); // R9
endmodule

bind sw_tlb sw_tlb_chk #(.VA_W(VA_W)) u_chk (.*);

// File: tb/tb_sw_tlb.sv
module tb_sw_tlb;
    localparam int SETS  = 64;
    localparam int WAYS  = 4;
    localparam int SET_W = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [59:0]  req_va = '0;
    logic [1:0]   req_acc = '0;
    logic         req_priv = 1'b0;
    logic [7:0]   req_asid = '0;
    logic         hnd_active = 1'b0;
    logic         inv_all = 1'b0;
    logic         sw_we = 1'b0;
    logic [SET_W-1:0] sw_set = '0;
    logic [1:0]   sw_way = '0;
    logic [127:0] sw_wdata = '0;
    logic [127:0] sw_rdata;
    logic         rsp_valid;
    logic [59:0]  rsp_pa;
    logic         rsp_cache;
    logic [1:0]   rsp_fault;
    logic         irq;
    logic [59:0]  trap_addr;
    logic [31:0]  trap_cause;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    sw_tlb #(.SETS(SETS), .WAYS(WAYS)) dut (.*);

    always #4 clk = ~clk;

    localparam logic [47:0] VPN_A = 48'h0000_1234_5601;
    localparam logic [47:0] PPN_A = 48'h0000_00FE_DC00;
    localparam logic [7:0]  PRM_A = 8'h3B;
    localparam logic [7:0]  ASID_A = 8'h05;
    localparam logic [47:0] VPN_B = 48'h0000_0ABC_0042;
    localparam logic [47:0] PPN_B = 48'h0000_0000_7770;

    function automatic logic [127:0] mk_ent(logic [47:0] vpn, logic [47:0] ppn,
                                             logic [7:0] perm, logic [7:0] asid, logic v);
        return {15'h0, v, asid, perm, ppn, vpn};
    endfunction

    function automatic logic [31:0] mk_cause(logic [3:0] kind, logic priv, logic [1:0] acc);
        return {16'h0, 4'h1, kind, 5'b0, priv, acc};
    endfunction

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic sw_write(logic [SET_W-1:0] s, logic [1:0] w, logic [127:0] d);
        sw_we = 1'b1; sw_set = s; sw_way = w; sw_wdata = d;
        tick();
        sw_we = 1'b0;
    endtask

    task automatic lookup(logic [59:0] va, logic [1:0] acc, logic priv, logic [7:0] asid);
        req_valid = 1'b1; req_va = va; req_acc = acc; req_priv = priv; req_asid = asid;
        tick();
        req_valid = 1'b0;
    endtask

    task automatic handler_cycle(string req);
        hnd_active = 1'b1;
        tick();
        chk(req, "irq cleared by handler", 128'(irq), 128'd0);
        hnd_active = 1'b0;
        tick();
    endtask

    task automatic t_reset();
        chk("R3", "irq after reset", 128'(irq), 128'd0);
        chk("R1", "rsp_valid after reset", 128'(rsp_valid), 128'd0);
        chk("R3", "trap_cause after reset", 128'(trap_cause), 128'd0);
    endtask

    task automatic t_hit();
        logic [59:0] va;
        va = {VPN_A, 12'hABC};
        sw_write(VPN_A[5:0], 2'd2, mk_ent(VPN_A, PPN_A, PRM_A, ASID_A, 1'b1));
        lookup(va, 2'd0, 1'b0, ASID_A);
        chk("R1", "user read pa", 128'(rsp_pa), 128'({PPN_A, 12'hABC}));
        chk("R1", "user read fault", 128'(rsp_fault), 128'd0);
        chk("R4", "user cacheable", 128'(rsp_cache), 128'd1);
        lookup(va, 2'd1, 1'b1, ASID_A);
        chk("R1", "super write fault", 128'(rsp_fault), 128'd0);
        chk("R4", "super not cacheable", 128'(rsp_cache), 128'd0);
        chk("R1", "no irq on hit", 128'(irq), 128'd0);
    endtask

    task automatic t_asid();
        logic [59:0] va;
        va = {VPN_A, 12'h010};
        lookup(va, 2'd0, 1'b0, 8'h06);
        chk("R2", "other asid misses", 128'(rsp_fault), 128'd1);
        chk("R2", "irq on asid miss", 128'(irq), 128'd1);
        handler_cycle("R2");
    endtask

    task automatic t_miss();
        logic [59:0] va1, va2;
        va1 = {VPN_B, 12'h123};
        va2 = {48'h0000_0000_9999, 12'h456};
        lookup(va1, 2'd2, 1'b1, ASID_A);
        chk("R3", "miss fault code", 128'(rsp_fault), 128'd1);
        chk("R3", "miss irq", 128'(irq), 128'd1);
        chk("R3", "miss trap_addr", 128'(trap_addr), 128'(va1));
        chk("R3", "miss cause", 128'(trap_cause), 128'(mk_cause(4'h1, 1'b1, 2'd2)));
        lookup(va2, 2'd0, 1'b0, ASID_A);
        chk("R5", "irq held", 128'(irq), 128'd1);
        chk("R5", "trap_addr kept first", 128'(trap_addr), 128'(va1));
        chk("R5", "trap_cause kept first", 128'(trap_cause), 128'(mk_cause(4'h1, 1'b1, 2'd2)));
        tick();
        chk("R5", "irq still held idle", 128'(irq), 128'd1);
        handler_cycle("R5");
    endtask

    task automatic t_prot();
        logic [59:0] va;
        va = {VPN_A, 12'h777};
        lookup(va, 2'd2, 1'b0, ASID_A);
        chk("R4", "user exec denied", 128'(rsp_fault), 128'd2);
        chk("R4", "prot irq", 128'(irq), 128'd1);
        chk("R4", "prot trap_addr", 128'(trap_addr), 128'(va));
        chk("R4", "prot cause", 128'(trap_cause), 128'(mk_cause(4'h2, 1'b0, 2'd2)));
        handler_cycle("R4");
        lookup(va, 2'd3, 1'b1, ASID_A);
        chk("R4", "reserved access denied", 128'(rsp_fault), 128'd2);
        handler_cycle("R4");
    endtask

    task automatic t_bypass();
        logic [59:0] va;
        logic [59:0] old_addr;
        va = {48'h0000_0000_5555, 12'h321};
        old_addr = trap_addr;
        hnd_active = 1'b1;
        tick();
        lookup(va, 2'd1, 1'b0, 8'h77);
        chk("R6", "bypass pa", 128'(rsp_pa), 128'(va));
        chk("R6", "bypass no fault", 128'(rsp_fault), 128'd0);
        chk("R6", "bypass no cache", 128'(rsp_cache), 128'd0);
        chk("R6", "bypass no irq", 128'(irq), 128'd0);
        chk("R6", "bypass trap_addr kept", 128'(trap_addr), 128'(old_addr));
        hnd_active = 1'b0;
        tick();
        chk("R6", "no irq after bypass", 128'(irq), 128'd0);
    endtask

    task automatic t_write_timing();
        logic [59:0] va;
        va = {VPN_B, 12'h0F0};
        sw_we = 1'b1; sw_set = VPN_B[5:0]; sw_way = 2'd1;
        sw_wdata = mk_ent(VPN_B, PPN_B, 8'h11, ASID_A, 1'b1);
        req_valid = 1'b1; req_va = va; req_acc = 2'd0; req_priv = 1'b1; req_asid = ASID_A;
        tick();
        sw_we = 1'b0; req_valid = 1'b0;
        chk("R7", "same-cycle lookup sees old", 128'(rsp_fault), 128'd1);
        handler_cycle("R7");
        lookup(va, 2'd0, 1'b1, ASID_A);
        chk("R7", "next lookup hits", 128'(rsp_fault), 128'd0);
        chk("R7", "next lookup pa", 128'(rsp_pa), 128'({PPN_B, 12'h0F0}));
    endtask

    task automatic t_readback();
        sw_set = VPN_B[5:0]; sw_way = 2'd1;
        tick();
        chk("R8", "readback entry", sw_rdata, mk_ent(VPN_B, PPN_B, 8'h11, ASID_A, 1'b1));
        sw_set = VPN_A[5:0]; sw_way = 2'd2;
        tick();
        chk("R8", "readback other entry", sw_rdata, mk_ent(VPN_A, PPN_A, PRM_A, ASID_A, 1'b1));
    endtask

    task automatic t_invalidate();
        inv_all = 1'b1;
        tick();
        inv_all = 1'b0;
        lookup({VPN_A, 12'h000}, 2'd0, 1'b0, ASID_A);
        chk("R9", "lookup after invalidate misses", 128'(rsp_fault), 128'd1);
        handler_cycle("R9");
        sw_set = VPN_A[5:0]; sw_way = 2'd2;
        tick();
        chk("R9", "readback valid cleared", 128'(sw_rdata[112]), 128'd0);
        chk("R9", "readback fields kept", 128'(sw_rdata[111:0]), 128'(mk_ent(VPN_A, PPN_A, PRM_A, ASID_A, 1'b0)));
    endtask

    task automatic t_return_run();
        logic [59:0] va;
        va = {48'h0000_0000_0123, 12'h004};
        lookup(va, 2'd1, 1'b0, ASID_A);
        chk("R10", "new trap irq", 128'(irq), 128'd1);
        chk("R10", "new trap_addr", 128'(trap_addr), 128'(va));
        chk("R10", "new cause", 128'(trap_cause), 128'(mk_cause(4'h1, 1'b0, 2'd1)));
        handler_cycle("R10");
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick();
        tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_hit();
        t_asid();
        t_miss();
        t_prot();
        t_bypass();
        t_write_timing();
        t_readback();
        t_invalidate();
        t_return_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule